// File: doc/BRIEF.md
# Dual-Clock Word FIFO with Programmable Level Flags

This block moves 36-bit words in one direction between two unrelated clock domains. A producer writes on its own clock whenever its write enable is high. A consumer removes the words in the same order on a separate clock with its own read enable. The two clocks run freely. They may have no phase or frequency relationship, or they may be the same clock. The buffer holds 64 words.

Each side sees only the flags it needs, and each flag is driven from that side's own clock. The producer gets `full` and `almostFull`. The consumer gets `empty` and `almostEmpty`. Each side keeps a binary pointer with one wrap bit and registers a Gray-coded copy of it. That copy passes through a chain of synchronizer flops into the other domain. The almost thresholds come from parameters and are loaded into level registers during reset.

Because the flags are computed from a pointer that was seen late, they are pessimistic. `full` and `empty` can release a few cycles after the opposite side has moved, but never before. Read data comes from a register and is updated only by an accepted read.

Top module: `cdc_word_fifo`

## Requirements
- R1: Words leave the read port in exactly the order they were accepted at the write port, and up to 64 words of 36 bits each can be stored at once.
- R2: A transfer happens only on the rising edge of its own port clock, and only while that port's enable is high. With both enables low, the flags and `rdData` do not change, even while `wrData` toggles.
- R3: A write presented while `full` is high is dropped. The write pointer does not move, and the word never appears at the read port.
- R4: A read presented while `empty` is high is dropped. The read pointer does not move, and `rdData` keeps its previous value.
- R5: While `rstN` is low and after it is released, `empty` and `almostEmpty` read 1, `full` and `almostFull` read 0, and `rdData` reads 0.
- R6: `full` is 1 exactly when the write side sees 64 stored words. After a read, `full` stays high for the next two write-clock edges and falls after the second of them, once the read pointer has passed the 2-stage synchronizer (coincident clocks).
- R7: `empty` is 1 when the read side sees no stored words. After a write, `empty` stays high for the next two read-clock edges and falls after the second of them (coincident clocks).
- R8: `almostFull` is 1 when the count seen by the write side is at least 64 minus `AF_OFFSET` (default 8, so 56 words or more).
- R9: `almostEmpty` is 1 when the count seen by the read side is at most `AE_OFFSET` (default 8 words).
- R10: `rdData` is registered. It presents the word taken by an accepted read right after the rising read-clock edge that accepts it.
- R11: With unrelated write and read clocks, a stream that repeatedly fills the buffer arrives complete and in order.
- R12: Each pointer crosses domains as a registered Gray code whose value changes by at most one bit per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset, asynchronous assertion, shared by both sides |
| wrEn | input | 1 | Write request, sampled on the rising edge of `wrClk` |
| wrData | input | 36 | Word to store |
| full | output | 1 | No free entry (write domain) |
| almostFull | output | 1 | Fill at or above the high level (write domain) |
| rdEn | input | 1 | Read request, sampled on the rising edge of `rdClk` |
| rdData | output | 36 | Last word read, registered |
| empty | output | 1 | No stored word (read domain) |
| almostEmpty | output | 1 | Fill at or below the low level (read domain) |

## Verification
The assertions check the following on every edge of the relevant clock:
- a write refused by `full` or a read refused by `empty` leaves its pointer where it was;
- `rdData` holds its value when no read is accepted;
- the fill seen by either side never exceeds 64;
- each full or empty flag implies its almost flag;
- each Gray pointer moves by at most one bit per edge.

Some behaviour can only be shown by the bench's scenarios:
- the exact synchronizer latency before `full` and `empty` release;
- the levels at which the almost flags switch;
- that words are kept and returned in order, including words dropped while full;
- a stream across two unrelated clocks.

// File: rtl/cdcf_pkg.sv
`timescale 1ns/1ps
package cdcf_pkg;
  // Per-cycle commands from the pointer logic to the storage.
  typedef struct packed {
    logic wrStrobe;   // wrClk domain: store wrData at wrAddr
    logic rdStrobe;   // rdClk domain: load rdData from rdAddr
  } strobe_t;
endpackage

// File: rtl/cdcf_sync.sv
`timescale 1ns/1ps
module cdcf_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cdcf_ctrl.sv
`timescale 1ns/1ps
module cdcf_ctrl #(
  parameter int DEPTH_LOG2  = 6,
  parameter int SYNC_STAGES = 2,
  parameter int AF_OFFSET   = 8,
  parameter int AE_OFFSET   = 8
) (
  input  logic                    wrClk,
  input  logic                    rdClk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic                    rdEn,
  output cdcf_pkg::strobe_t       strobes,
  output logic [DEPTH_LOG2-1:0]   wrAddr,
  output logic [DEPTH_LOG2-1:0]   rdAddr,
  output logic                    full,
  output logic                    almostFull,
  output logic                    empty,
  output logic                    almostEmpty
);
  localparam int PTR_W = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] AF_LEVEL = PTR_W'(DEPTH - AF_OFFSET);
  localparam logic [PTR_W-1:0] AE_LEVEL = PTR_W'(AE_OFFSET);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] toBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wPtr, wGray, rGraySeen, rPtrSeen, wFill, afLevel;
  logic             wrAccept;

  assign wrAccept = wrEn & ~full;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wPtr    <= '0;
      wGray   <= '0;
      afLevel <= AF_LEVEL;
    end else if (wrAccept) begin
      wPtr  <= wPtr + PTR_W'(1);
      wGray <= toGray(wPtr + PTR_W'(1));
    end
  end

  cdcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) rdPtrSync_i (
    .clk(wrClk), .rstN(rstN), .din(rGray), .dout(rGraySeen)
  );

  assign rPtrSeen   = toBin(rGraySeen);
  assign wFill      = wPtr - rPtrSeen;
  assign full       = (wFill == FULL_CNT);
  assign almostFull = (wFill >= afLevel);
  assign wrAddr     = wPtr[DEPTH_LOG2-1:0];

  // ---------------- read domain ----------------
  logic [PTR_W-1:0] rPtr, rGray, wGraySeen, wPtrSeen, rFill, aeLevel;
  logic             rdAccept;

  assign rdAccept = rdEn & ~empty;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rPtr    <= '0;
      rGray   <= '0;
      aeLevel <= AE_LEVEL;
    end else if (rdAccept) begin
      rPtr  <= rPtr + PTR_W'(1);
      rGray <= toGray(rPtr + PTR_W'(1));
    end
  end

  cdcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) wrPtrSync_i (
    .clk(rdClk), .rstN(rstN), .din(wGray), .dout(wGraySeen)
  );

  assign wPtrSeen    = toBin(wGraySeen);
  assign rFill       = wPtrSeen - rPtr;
  assign empty       = (rFill == '0);
  assign almostEmpty = (rFill <= aeLevel);
  assign rdAddr      = rPtr[DEPTH_LOG2-1:0];

  assign strobes = '{wrStrobe: wrAccept, rdStrobe: rdAccept};

  // ---------------- assertions ----------------
  p_no_overflow_r3: assert property (@(posedge wrClk) disable iff (!rstN)
    (wrEn && full) |=> $stable(wPtr));
  p_no_underflow_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdEn && empty) |=> $stable(rPtr));
  p_wfill_bound_r6: assert property (@(posedge wrClk) disable iff (!rstN)
    wFill <= FULL_CNT);
  p_rfill_bound_r7: assert property (@(posedge rdClk) disable iff (!rstN)
    rFill <= FULL_CNT);
  p_full_in_af_r8: assert property (@(posedge wrClk) disable iff (!rstN)
    full |-> almostFull);
  p_empty_in_ae_r9: assert property (@(posedge rdClk) disable iff (!rstN)
    empty |-> almostEmpty);
  p_wgray_step_r12: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0(wGray ^ $past(wGray)));
  p_rgray_step_r12: assert property (@(posedge rdClk) disable iff (!rstN)
    $onehot0(rGray ^ $past(rGray)));
endmodule

// File: rtl/cdcf_store.sv
`timescale 1ns/1ps
module cdcf_store #(
  parameter int DATA_W     = 36,
  parameter int DEPTH_LOG2 = 6
) (
  input  logic                  wrClk,
  input  logic                  rdClk,
  input  logic                  rstN,
  input  cdcf_pkg::strobe_t     strobes,
  input  logic [DEPTH_LOG2-1:0] wrAddr,
  input  logic [DEPTH_LOG2-1:0] rdAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic [DATA_W-1:0]     rdData
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobes.wrStrobe) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                 rdData <= '0;
    else if (strobes.rdStrobe) rdData <= mem[rdAddr];
  end

  // R4 / R10: output register moves only on an accepted read
  p_rd_hold_r4: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/cdc_word_fifo.sv
`timescale 1ns/1ps
module cdc_word_fifo #(
  parameter int DATA_W      = 36,
  parameter int DEPTH_LOG2  = 6,
  parameter int SYNC_STAGES = 2,
  parameter int AF_OFFSET   = 8,
  parameter int AE_OFFSET   = 8
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              full,
  output logic              almostFull,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              empty,
  output logic              almostEmpty
);
  cdcf_pkg::strobe_t     strobes;
  logic [DEPTH_LOG2-1:0] wrAddr, rdAddr;

  cdcf_ctrl #(
    .DEPTH_LOG2(DEPTH_LOG2), .SYNC_STAGES(SYNC_STAGES),
    .AF_OFFSET(AF_OFFSET), .AE_OFFSET(AE_OFFSET)
  ) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .rdEn(rdEn),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .full(full), .almostFull(almostFull),
    .empty(empty), .almostEmpty(almostEmpty)
  );

  cdcf_store #(.DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2)) store_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/cdc_word_fifo_tb_top.sv
`timescale 1ns/1ps
module cdc_word_fifo_tb_top;
  localparam int DW  = 36;
  localparam int CAP = 64;

  logic wrClk = 1'b0, slowClk = 1'b0, coincident = 1'b1;
  logic rdClk;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic full, almostFull, empty, almostEmpty;

  always #4 wrClk = ~wrClk;        // 125 MHz
  always #6.5 slowClk = ~slowClk;  // unrelated read clock for the stream test
  assign rdClk = coincident ? wrClk : slowClk;

  cdc_word_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn(wrEn), .wrData(wrData), .full(full), .almostFull(almostFull),
    .rdEn(rdEn), .rdData(rdData), .empty(empty), .almostEmpty(almostEmpty)
  );

  int nChecks = 0, nFails = 0;
  logic [DW-1:0] model [CAP];
  int mHead = 0, mCount = 0, seq = 0;
  logic [DW-1:0] lastRd = '0;

  function automatic logic [DW-1:0] wordOf(input int n);
    return {4'(n), 32'(n * 32'h01000193 + 32'h5A5)};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {empty, almostEmpty, almostFull, full}
  function automatic logic [3:0] flags();
    return {empty, almostEmpty, almostFull, full};
  endfunction

  // Coincident clocks; every task starts and ends at a falling edge.
  task automatic writeBurst(input int n);
    for (int i = 0; i < n; i++) begin
      wrEn = 1'b1; wrData = wordOf(seq);
      @(negedge wrClk);
      if (mCount < CAP) begin   // R3: refused when the model is full
        model[(mHead + mCount) % CAP] = wordOf(seq);
        mCount++;
      end
      seq++;
    end
    wrEn = 1'b0;
  endtask

  task automatic readBurst(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      rdEn = 1'b1;
      @(negedge rdClk);
      if (mCount > 0) begin
        check(req, rdData, model[mHead]);
        lastRd = model[mHead];
        mHead = (mHead + 1) % CAP; mCount--;
      end else begin
        check("R4 read while empty holds rdData", rdData, lastRd);
      end
    end
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge wrClk);
  endtask

  typedef struct packed { int nWr; int nRd; logic [3:0] exp; } vec_t;
  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1,  0, 4'b0100},   // 1 word
    '{7,  0, 4'b0100},   // 8: still almost empty (R9)
    '{1,  0, 4'b0000},   // 9
    '{46, 0, 4'b0000},   // 55
    '{1,  0, 4'b0010},   // 56: almost full (R8)
    '{8,  0, 4'b0011},   // 64: full (R6)
    '{3,  0, 4'b0011},   // refused writes (R3)
    '{0,  1, 4'b0010},   // 63
    '{0, 55, 4'b0100},   // 8
    '{0,  8, 4'b1100},   // 0: empty (R7)
    '{0,  2, 4'b1100},   // refused reads (R4)
    '{5,  0, 4'b0100},   // 5
    '{0,  5, 4'b1100}    // 0
  };

  initial begin : watchdog
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [DW-1:0] held;
    repeat (3) @(negedge wrClk);
    check("R5 flags in reset", 64'(flags()), 64'(4'b1100));
    rstN = 1'b1;
    @(negedge wrClk);
    check("R5 flags after reset", 64'(flags()), 64'(4'b1100));
    check("R5 rdData after reset", rdData, 0);

    // R2: enables low, data toggling -> nothing changes
    for (int i = 0; i < 5; i++) begin
      wrData = wordOf(1000 + i);
      @(negedge wrClk);
    end
    check("R2 no transfer without enable", 64'(flags()), 64'(4'b1100));
    check("R2 rdData unchanged without enable", rdData, 0);

    // Vector table: fill levels and flags, data in order (R1)
    for (int v = 0; v < NV; v++) begin
      writeBurst(VEC[v].nWr);
      readBurst(VEC[v].nRd, "R1 order");
      settle();
      check("R6/R7/R8/R9 flags", 64'(flags()), 64'(VEC[v].exp));
    end

    // R7: empty releases after the second read-clock edge
    wrEn = 1'b1; wrData = wordOf(seq);
    @(negedge wrClk);                 // after write edge k
    wrEn = 1'b0;
    model[(mHead + mCount) % CAP] = wordOf(seq); mCount++; seq++;
    check("R7 empty at k", empty, 1);
    @(negedge wrClk);
    check("R7 empty at k+1", empty, 1);
    @(negedge wrClk);
    check("R7 empty clears at k+2", empty, 0);
    // R10: registered read data right after the accepting edge
    held = rdData;
    check("R10 rdData before read", rdData, held);
    readBurst(1, "R10 read data after accepting edge");
    settle();

    // R6: fill, push two refused words, then watch full release
    writeBurst(CAP + 2);
    settle();
    check("R6 full at 64", full, 1);
    rdEn = 1'b1;
    @(negedge rdClk);                 // after read edge k
    rdEn = 1'b0;
    check("R6 data of first read", rdData, model[mHead]);
    lastRd = model[mHead]; mHead = (mHead + 1) % CAP; mCount--;
    check("R6 full at k", full, 1);
    @(negedge wrClk);
    check("R6 full at k+1", full, 1);
    @(negedge wrClk);
    check("R6 full clears at k+2", full, 0);
    readBurst(CAP - 1, "R3 refused words never stored");
    settle();
    check("R3 drained after refused writes", 64'(flags()), 64'(4'b1100));

    // R11/R12: unrelated clocks, continuous stream
    rstN = 1'b0;
    @(negedge wrClk);
    coincident = 1'b0;
    repeat (4) @(negedge wrClk);
    rstN = 1'b1;
    fork
      begin : writer
        for (int sent = 0; sent < 150; ) begin
          @(negedge wrClk);
          if (!full) begin
            wrEn = 1'b1; wrData = wordOf(5000 + sent); sent++;
          end else begin
            wrEn = 1'b1; wrData = '1;   // refused while full
          end
          @(posedge wrClk);
        end
        @(negedge wrClk);
        wrEn = 1'b0;
      end
      begin : reader
        int recv = 0;
        logic pend = 1'b0;
        while (recv < 150) begin
          @(negedge slowClk);
          if (pend) begin
            check("R11/R12 stream order", rdData, wordOf(5000 + recv));
            recv++;
          end
          pend = !empty && (recv < 150);
          rdEn = pend;
        end
        rdEn = 1'b0;
      end
    join
    repeat (6) @(negedge slowClk);
    check("R11 stream drained", 64'({empty, almostEmpty}), 64'(2'b11));
    check("R11 write side sees empty", 64'({almostFull, full}), 64'(2'b00));

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule